// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block decides, once per clock, whether the core enters a trap and which kind. The candidates are a hardware or software reset request, a break request, a program or software trap, and the highest pending external interrupt. For the chosen entry it produces every write-back in one registered bundle, and all of these take effect on the same clock edge:

- the new program counter;
- the updated supervisor, previous-supervisor and trap-enable status bits;
- the break status copy;
- the return address, in either the break save register or the ordinary save register;
- the trap base register with its type field filled in.

External interrupt levels 1 to 15 are latched into a pending set. Each accepted interrupt removes its own bit from that set.

The surrounding core drives the current status bits, the interrupt level threshold, the trap base register, and the current and previous-bundle program counters. It applies the write-backs in the cycle after the request. The block also keeps a sticky debug flag, set by a break, and a sticky halt flag, set by a program trap taken while traps were disabled. Any reset request clears both flags.

Top module: `trap_entry_top`

## Requirements
- R1: A hardware reset request, or a software reset request, writes only the PC. Hardware takes precedence and reports kind 1; software reports kind 2. The PC is 0xFF000000 when cfgStartHigh is 1 and 0 otherwise. Either request clears halted and debugMode. A hardware reset also empties the pending set.
- R2: Only one entry is taken per cycle. The priority is reset, then break (kind 3), then program trap (kind 4), then external interrupt (kind 5). A request that loses is not remembered, except that an external interrupt stays pending.
- R3: A break saves curPc in bpcOut. It copies statSuper and statTrapEn into brkSuperOut and brkTrapEnOut. It writes supervisor=1 and trap-enable=0, and leaves the previous-supervisor bit unwritten.
- R4: A break writes type 0xFF into tbrOut bits [11:4]. tbrOut keeps tbrIn bits [31:12] and has bits [3:0] at zero. The PC becomes tbrOut, and debugMode is set.
- R5: A program trap writes previous-supervisor = statSuper, supervisor = 1 and trap-enable = 0. It puts progOffset into the type field, and the PC becomes the resulting tbrOut.
- R6: A precise program trap saves prevPc in epcOut. An imprecise one saves curPc.
- R7: A program trap taken with statTrapEn = 0 still performs every write-back and then sets halted. While halted, only a reset request is taken; raised interrupts are still recorded.
- R8: An external interrupt stays pending while statTrapEn is 0. It also stays pending while its level is below statPil, except that level 15 is always accepted. A raise with level 0 is ignored.
- R9: An accepted external interrupt saves curPc in epcOut and makes the same status and PC updates as a program trap. Its type is 0x10 plus its level. Its pending bit is cleared.
- R10: When several external levels are pending, the highest level is the one considered.
- R11: Outputs are registered, and appear one cycle after the request. Every write-enable and every data output is 0 in cycles with no entry and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstHardReq | input | 1 | Hardware reset request |
| rstSoftReq | input | 1 | Software reset request |
| cfgStartHigh | input | 1 | Selects the high reset vector |
| brkReq | input | 1 | Break request |
| progReq | input | 1 | Program or software trap request |
| progPrecise | input | 1 | The program trap is precise |
| progOffset | input | 8 | Handler type for the program trap |
| extRaise | input | 1 | Adds an external interrupt level to the pending set |
| extRaiseLevel | input | 4 | Level being raised |
| curPc | input | 32 | Current PC |
| prevPc | input | 32 | PC of the previous instruction bundle |
| statSuper | input | 1 | Current supervisor bit |
| statTrapEn | input | 1 | Current trap-enable bit |
| statPil | input | 4 | Interrupt level threshold |
| tbrIn | input | 32 | Current trap base register |
| takeKind | output | 3 | Entry taken: 0 none, 1 hardware reset, 2 software reset, 3 break, 4 program, 5 external |
| pcWe | output | 1 | PC write |
| pcNext | output | 32 | New PC |
| statWe | output | 1 | Supervisor and trap-enable write |
| statSuperOut | output | 1 | New supervisor bit |
| statTrapEnOut | output | 1 | New trap-enable bit |
| statPrevWe | output | 1 | Previous-supervisor write |
| statPrevSuperOut | output | 1 | New previous-supervisor bit |
| brkStatWe | output | 1 | Break status write |
| brkSuperOut | output | 1 | Saved supervisor bit |
| brkTrapEnOut | output | 1 | Saved trap-enable bit |
| bpcWe | output | 1 | Break PC save write |
| bpcOut | output | 32 | Break PC save value |
| epcWe | output | 1 | Ordinary PC save write |
| epcOut | output | 32 | Ordinary PC save value |
| tbrWe | output | 1 | Trap base register write |
| tbrOut | output | 32 | New trap base register |
| extPending | output | 16 | Pending external levels, one bit per level |
| debugMode | output | 1 | Sticky debug state |
| halted | output | 1 | Sticky stopped state |

## Verification
Directed steps come first, and each one isolates one contested point:

- Hardware and software reset requests raised together show which of the two takes precedence.
- Break and program requests issued with the supervisor and trap-enable bits differing show whether each bit is copied into the correct save field.
- A precise and an imprecise program trap with distinct current and previous PCs show which save source is used.
- Levels raised on both sides of the threshold, with level 15 raised at the highest threshold, separate highest-first selection from masking and from the non-maskable exception.
- Program and external requests in the same cycle, and any requests made while halted, show which request wins and what is dropped or kept.

A long mixed random stream then checks every output against a behavioural model on each clock.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int LVL_W = 4;

  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_HARD = 3'd1,
    KIND_SOFT = 3'd2,
    KIND_BRK  = 3'd3,
    KIND_PROG = 3'd4,
    KIND_EXT  = 3'd5
  } trapKind_e;

  typedef struct packed {
    logic             takeHard;
    logic             takeSoft;
    logic             takeBrk;
    logic             takeProg;
    logic             takeExt;
    logic             usePrev;
    logic [LVL_W-1:0] extLevel;
  } trapStrobe_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int NUM_LEVELS = 16,
  parameter int NMI_LEVEL  = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rstHardReq,
  input  logic                  rstSoftReq,
  input  logic                  brkReq,
  input  logic                  progReq,
  input  logic                  progPrecise,
  input  logic                  extRaise,
  input  logic [LVL_W-1:0]      extRaiseLevel,
  input  logic                  statTrapEn,
  input  logic [LVL_W-1:0]      statPil,
  output trapStrobe_t           strobe,
  output logic [NUM_LEVELS-1:0] pending,
  output logic                  halted,
  output logic                  debugMode
);
  logic [NUM_LEVELS-1:0] pendNext;
  logic [LVL_W-1:0]      topLevel;
  logic                  topFound;
  logic                  extOk;

  // highest pending level wins the scan
  always_comb begin
    topLevel = '0;
    topFound = 1'b0;
    for (int i = 1; i < NUM_LEVELS; i++) begin
      if (pending[i]) begin
        topLevel = LVL_W'(i);
        topFound = 1'b1;
      end
    end
  end

  assign extOk = topFound && statTrapEn &&
                 ((topLevel == LVL_W'(NMI_LEVEL)) || (topLevel >= statPil));

  always_comb begin
    strobe          = '0;
    strobe.usePrev  = progPrecise;
    strobe.extLevel = topLevel;
    if (rstHardReq)      strobe.takeHard = 1'b1;
    else if (rstSoftReq) strobe.takeSoft = 1'b1;
    else if (!halted) begin
      if (brkReq)       strobe.takeBrk  = 1'b1;
      else if (progReq) strobe.takeProg = 1'b1;
      else if (extOk)   strobe.takeExt  = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLvl
    if (g == 0) begin : gNone
      assign pendNext[g] = 1'b0;
    end else begin : gReal
      assign pendNext[g] = !strobe.takeHard &&
        (pending[g] || (extRaise && extRaiseLevel == LVL_W'(g))) &&
        !(strobe.takeExt && strobe.extLevel == LVL_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= '0;
      halted    <= 1'b0;
      debugMode <= 1'b0;
    end else begin
      pending <= pendNext;
      if (strobe.takeHard || strobe.takeSoft) begin
        halted    <= 1'b0;
        debugMode <= 1'b0;
      end else begin
        if (strobe.takeProg && !statTrapEn) halted <= 1'b1;
        if (strobe.takeBrk) debugMode <= 1'b1;
      end
    end
  end

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rstHardReq && !rstSoftReq) |=> halted);
  assert_ext_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeExt |-> statTrapEn);
  assert_hard_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rstHardReq |=> (pending == '0));
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int                XLEN         = 32,
  parameter int                TT_W         = 8,
  parameter int                TT_LSB       = 4,
  parameter logic [TT_W-1:0]   BRK_TT       = 8'hFF,
  parameter logic [TT_W-1:0]   EXT_TT_BASE  = 8'h10,
  parameter logic [XLEN-1:0]   RESET_HI_VEC = 32'hFF00_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trapStrobe_t     strobe,
  input  logic            cfgStartHigh,
  input  logic [TT_W-1:0] progOffset,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] prevPc,
  input  logic            statSuper,
  input  logic            statTrapEn,
  input  logic [XLEN-1:0] tbrIn,
  output logic [2:0]      takeKind,
  output logic            pcWe,
  output logic [XLEN-1:0] pcNext,
  output logic            statWe,
  output logic            statSuperOut,
  output logic            statTrapEnOut,
  output logic            statPrevWe,
  output logic            statPrevSuperOut,
  output logic            brkStatWe,
  output logic            brkSuperOut,
  output logic            brkTrapEnOut,
  output logic            bpcWe,
  output logic [XLEN-1:0] bpcOut,
  output logic            epcWe,
  output logic [XLEN-1:0] epcOut,
  output logic            tbrWe,
  output logic [XLEN-1:0] tbrOut
);
  localparam int BASE_LSB = TT_LSB + TT_W;
  localparam logic [XLEN-1:0] KEEP_MASK =
    {{(XLEN-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};

  logic [TT_W-1:0] tt;
  logic [XLEN-1:0] tbrVal;
  logic            anyTrap, anyReset;
  logic [2:0]      kindD;

  always_comb begin
    anyTrap  = strobe.takeBrk | strobe.takeProg | strobe.takeExt;
    anyReset = strobe.takeHard | strobe.takeSoft;
    if (strobe.takeBrk)       tt = BRK_TT;
    else if (strobe.takeProg) tt = progOffset;
    else                      tt = TT_W'(EXT_TT_BASE + TT_W'(strobe.extLevel));
    tbrVal = (tbrIn & KEEP_MASK) | (XLEN'(tt) << TT_LSB);
    if (strobe.takeHard)      kindD = KIND_HARD;
    else if (strobe.takeSoft) kindD = KIND_SOFT;
    else if (strobe.takeBrk)  kindD = KIND_BRK;
    else if (strobe.takeProg) kindD = KIND_PROG;
    else if (strobe.takeExt)  kindD = KIND_EXT;
    else                      kindD = KIND_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      takeKind <= '0; pcWe <= 1'b0; pcNext <= '0;
      statWe <= 1'b0; statSuperOut <= 1'b0; statTrapEnOut <= 1'b0;
      statPrevWe <= 1'b0; statPrevSuperOut <= 1'b0;
      brkStatWe <= 1'b0; brkSuperOut <= 1'b0; brkTrapEnOut <= 1'b0;
      bpcWe <= 1'b0; bpcOut <= '0; epcWe <= 1'b0; epcOut <= '0;
      tbrWe <= 1'b0; tbrOut <= '0;
    end else begin
      takeKind         <= kindD;
      pcWe             <= anyTrap | anyReset;
      pcNext           <= anyReset ? (cfgStartHigh ? RESET_HI_VEC : '0)
                        : (anyTrap ? tbrVal : '0);
      statWe           <= anyTrap;
      statSuperOut     <= anyTrap;
      statTrapEnOut    <= 1'b0;
      statPrevWe       <= strobe.takeProg | strobe.takeExt;
      statPrevSuperOut <= (strobe.takeProg | strobe.takeExt) & statSuper;
      brkStatWe        <= strobe.takeBrk;
      brkSuperOut      <= strobe.takeBrk & statSuper;
      brkTrapEnOut     <= strobe.takeBrk & statTrapEn;
      bpcWe            <= strobe.takeBrk;
      bpcOut           <= strobe.takeBrk ? curPc : '0;
      epcWe            <= strobe.takeProg | strobe.takeExt;
      epcOut           <= (strobe.takeProg && strobe.usePrev) ? prevPc
                        : ((strobe.takeProg | strobe.takeExt) ? curPc : '0);
      tbrWe            <= anyTrap;
      tbrOut           <= anyTrap ? tbrVal : '0;
    end
  end

  assert_single_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bpcWe && epcWe));
  assert_brk_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brkStatWe |-> (statWe && statSuperOut && !statTrapEnOut && !statPrevWe));
  assert_entry_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeHard || strobe.takeSoft || strobe.takeBrk ||
     strobe.takeProg || strobe.takeExt) |=> pcWe);
  assert_trap_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbrWe |-> (pcNext == tbrOut));
endmodule

// File: rtl/trap_entry_top.sv
module trap_entry_top
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TT_W       = 8,
  parameter int TT_LSB     = 4,
  parameter int NUM_LEVELS = 16,
  parameter int NMI_LEVEL  = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rstHardReq,
  input  logic                  rstSoftReq,
  input  logic                  cfgStartHigh,
  input  logic                  brkReq,
  input  logic                  progReq,
  input  logic                  progPrecise,
  input  logic [TT_W-1:0]       progOffset,
  input  logic                  extRaise,
  input  logic [3:0]            extRaiseLevel,
  input  logic [XLEN-1:0]       curPc,
  input  logic [XLEN-1:0]       prevPc,
  input  logic                  statSuper,
  input  logic                  statTrapEn,
  input  logic [3:0]            statPil,
  input  logic [XLEN-1:0]       tbrIn,
  output logic [2:0]            takeKind,
  output logic                  pcWe,
  output logic [XLEN-1:0]       pcNext,
  output logic                  statWe,
  output logic                  statSuperOut,
  output logic                  statTrapEnOut,
  output logic                  statPrevWe,
  output logic                  statPrevSuperOut,
  output logic                  brkStatWe,
  output logic                  brkSuperOut,
  output logic                  brkTrapEnOut,
  output logic                  bpcWe,
  output logic [XLEN-1:0]       bpcOut,
  output logic                  epcWe,
  output logic [XLEN-1:0]       epcOut,
  output logic                  tbrWe,
  output logic [XLEN-1:0]       tbrOut,
  output logic [NUM_LEVELS-1:0] extPending,
  output logic                  debugMode,
  output logic                  halted
);
  trapStrobe_t strobe;

  trap_ctrl #(.NUM_LEVELS(NUM_LEVELS), .NMI_LEVEL(NMI_LEVEL)) uCtrl (
    .clk(clk), .rst_n(rst_n), .rstHardReq(rstHardReq), .rstSoftReq(rstSoftReq),
    .brkReq(brkReq), .progReq(progReq), .progPrecise(progPrecise),
    .extRaise(extRaise), .extRaiseLevel(extRaiseLevel),
    .statTrapEn(statTrapEn), .statPil(statPil), .strobe(strobe),
    .pending(extPending), .halted(halted), .debugMode(debugMode)
  );

  trap_dp #(.XLEN(XLEN), .TT_W(TT_W), .TT_LSB(TT_LSB)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgStartHigh(cfgStartHigh),
    .progOffset(progOffset), .curPc(curPc), .prevPc(prevPc),
    .statSuper(statSuper), .statTrapEn(statTrapEn), .tbrIn(tbrIn),
    .takeKind(takeKind), .pcWe(pcWe), .pcNext(pcNext), .statWe(statWe),
    .statSuperOut(statSuperOut), .statTrapEnOut(statTrapEnOut),
    .statPrevWe(statPrevWe), .statPrevSuperOut(statPrevSuperOut),
    .brkStatWe(brkStatWe), .brkSuperOut(brkSuperOut), .brkTrapEnOut(brkTrapEnOut),
    .bpcWe(bpcWe), .bpcOut(bpcOut), .epcWe(epcWe), .epcOut(epcOut),
    .tbrWe(tbrWe), .tbrOut(tbrOut)
  );
endmodule

// File: tb/sim_trap_entry_top.sv
module sim_trap_entry_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rstHardReq, rstSoftReq, cfgStartHigh, brkReq, progReq, progPrecise;
  logic [7:0] progOffset;
  logic extRaise;
  logic [3:0] extRaiseLevel, statPil;
  logic [31:0] curPc, prevPc, tbrIn;
  logic statSuper, statTrapEn;
  logic [2:0] takeKind;
  logic pcWe, statWe, statSuperOut, statTrapEnOut, statPrevWe, statPrevSuperOut;
  logic brkStatWe, brkSuperOut, brkTrapEnOut, bpcWe, epcWe, tbrWe, debugMode, halted;
  logic [31:0] pcNext, bpcOut, epcOut, tbrOut;
  logic [15:0] extPending;

  trap_entry_top u0 (.*);

  int checks = 0, errors = 0;
  logic [15:0] mPend = '0;
  logic mHalt = 1'b0, mDbg = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rstHardReq = 0; rstSoftReq = 0; brkReq = 0; progReq = 0; progPrecise = 0;
    extRaise = 0; extRaiseLevel = 0;
  endtask

  // one clock: predict, advance, compare
  task automatic cycle();
    int top = 0;
    int kind = 0;
    logic [7:0] tt;
    logic [31:0] tv, ePc, eEpc;
    logic [15:0] nPend;
    logic sHalt, sDbg, sSuper, sEt;
    string tg;
    for (int i = 1; i < 16; i++) if (mPend[i]) top = i;
    sSuper = statSuper; sEt = statTrapEn;
    if (rstHardReq) kind = 1;
    else if (rstSoftReq) kind = 2;
    else if (!mHalt) begin
      if (brkReq) kind = 3;
      else if (progReq) kind = 4;
      else if (top > 0 && statTrapEn && (top == 15 || top >= int'(statPil))) kind = 5;
    end
    tt = (kind == 3) ? 8'hFF : (kind == 4) ? progOffset : 8'(8'h10 + top);
    tv = {tbrIn[31:12], tt, 4'h0};
    ePc = (kind == 0) ? 32'h0 : (kind <= 2) ? (cfgStartHigh ? 32'hFF00_0000 : 32'h0) : tv;
    eEpc = (kind == 4 && progPrecise) ? prevPc : ((kind == 4 || kind == 5) ? curPc : 32'h0);
    nPend = mPend;
    if (extRaise && extRaiseLevel != 0) nPend[extRaiseLevel] = 1'b1;
    if (kind == 5) nPend[top] = 1'b0;
    if (kind == 1) nPend = '0;
    sHalt = mHalt; sDbg = mDbg;
    if (kind == 1 || kind == 2) begin sHalt = 0; sDbg = 0; end
    if (kind == 4 && !sEt) sHalt = 1;
    if (kind == 3) sDbg = 1;
    tg = (kind == 0) ? "R11" : (kind <= 2) ? "R1" : (kind == 3) ? "R3" : (kind == 4) ? "R5" : "R9";
    // kinds: R1 reset, R3 break, R5 program, R9 external, R11 idle
    tv = (kind >= 3) ? tv : 32'h0;
    @(posedge clk);
    @(negedge clk);
    mPend = nPend; mHalt = sHalt; mDbg = sDbg;
    chk("R2", "takeKind", 32'(takeKind), 32'(kind));
    chk(tg, "pcWe", 32'(pcWe), 32'(kind != 0));
    chk(tg, "pcNext", pcNext, ePc);
    chk(tg, "statWe", 32'(statWe), 32'(kind >= 3));
    chk(tg, "statSuperOut", 32'(statSuperOut), 32'(kind >= 3));
    chk(tg, "statTrapEnOut", 32'(statTrapEnOut), 32'h0);
    chk(tg, "statPrevWe", 32'(statPrevWe), 32'(kind == 4 || kind == 5));
    chk(tg, "statPrevSuperOut", 32'(statPrevSuperOut), 32'((kind == 4 || kind == 5) && sSuper));
    chk("R3", "brkStatWe", 32'(brkStatWe), 32'(kind == 3));
    chk("R3", "brkSuperOut", 32'(brkSuperOut), 32'(kind == 3 && sSuper));
    chk("R3", "brkTrapEnOut", 32'(brkTrapEnOut), 32'(kind == 3 && sEt));
    chk("R3", "bpcWe", 32'(bpcWe), 32'(kind == 3));
    chk("R3", "bpcOut", bpcOut, (kind == 3) ? curPc : 32'h0);
    chk("R6", "epcWe", 32'(epcWe), 32'(kind == 4 || kind == 5));
    chk("R6", "epcOut", epcOut, eEpc);
    chk("R4", "tbrWe", 32'(tbrWe), 32'(kind >= 3));
    chk("R4", "tbrOut", tbrOut, tv);
    chk("R8", "extPending", 32'(extPending), 32'(mPend));
    chk("R7", "halted", 32'(halted), 32'(mHalt));
    chk("R4", "debugMode", 32'(debugMode), 32'(mDbg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    rst_n = 0; idle(); cfgStartHigh = 0; progOffset = 8'h21;
    curPc = 32'h0000_1000; prevPc = 32'h0000_0FF8; tbrIn = 32'hABCD_E5A7;
    statSuper = 0; statTrapEn = 1; statPil = 4'd5;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset pcWe", 32'(pcWe), 0);
    chk("R11", "reset pending", 32'(extPending), 0);
    chk("R11", "reset halted", 32'(halted), 0);
    rst_n = 1;
    cycle();
    // R1 both resets: hardware wins, high vector
    rstHardReq = 1; rstSoftReq = 1; cfgStartHigh = 1; cycle(); idle();
    rstSoftReq = 1; cfgStartHigh = 0; cycle(); idle();
    // R3 R4 break with supervisor 0, trap-enable 1
    brkReq = 1; cycle(); idle();
    // R2 break beats program
    statSuper = 1; brkReq = 1; progReq = 1; cycle(); idle();
    // R5 R6 imprecise then precise program trap
    progReq = 1; cycle();
    progPrecise = 1; progOffset = 8'h3C; cycle(); idle();
    // R8 R10 levels 3 and 7 with threshold 5
    extRaise = 1; extRaiseLevel = 3; cycle();
    extRaiseLevel = 7; cycle();
    extRaiseLevel = 0; cycle(); idle();
    cycle(); cycle();
    // R8 level 15 at threshold 15, trap-enable low first
    statPil = 4'd15; statTrapEn = 0; extRaise = 1; extRaiseLevel = 15; cycle(); idle();
    cycle(); statTrapEn = 1; cycle(); cycle();
    // R2 program beats a pending external interrupt
    statPil = 0; progReq = 1; cycle(); idle(); cycle();
    // R7 program trap with traps disabled halts; later requests dropped
    statTrapEn = 0; progReq = 1; cycle(); idle();
    statTrapEn = 1; brkReq = 1; extRaise = 1; extRaiseLevel = 9; cycle(); idle();
    cycle();
    rstSoftReq = 1; cycle(); idle(); cycle();
    rstHardReq = 1; cycle(); idle();
    // mixed stream
    for (int n = 0; n < 3000; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      rstHardReq = (lfsr[31:26] == 0); rstSoftReq = (lfsr[25:20] == 1);
      cfgStartHigh = lfsr[3]; brkReq = (lfsr[19:17] == 0);
      progReq = (lfsr[16:14] == 0); progPrecise = lfsr[13];
      progOffset = lfsr[12:5]; extRaise = lfsr[4]; extRaiseLevel = lfsr[30:27];
      statSuper = lfsr[2]; statTrapEn = (lfsr[1:0] != 0); statPil = lfsr[11:8];
      curPc = lfsr ^ 32'h5555_0000; prevPc = ~lfsr; tbrIn = {lfsr[15:0], lfsr[31:16]};
      cycle();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule